// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This is the arithmetic and logic unit of an 8-bit accumulator machine. It is purely combinational. It takes two operands, an incoming carry, the present condition-code flags and an operation code. In the same cycle it returns a result, the next value of each of the five status flags (half-carry H, negative N, zero Z, overflow V, carry C) and a write enable for each flag. It also returns a write enable for the result, so that the surrounding datapath knows which destination registers to update.

Byte operations cover the following:
- add, and add with carry;
- subtract, subtract with borrow, and compare;
- AND, OR and XOR;
- one's complement;
- test against zero;
- bit test;
- rotate left and right through the carry;
- shift left, arithmetic shift right and logical shift right.

A small set of double-width (16-bit) operations serves a paired-accumulator register: add, subtract, compare, shift left and logical shift right. Each operation has its own policy for which flags it writes. A flag that is not written is returned unchanged from `flags_i`.

Top module: `alu8`

## Requirements
- R1: Operation codes (5 bits) are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, XOR=7, COM=8, TST=9, BIT=10, ROL=11, ROR=12, ASL=13, ASR=14, LSR=15, ADDW=16, SUBW=17, CMPW=18, ASLW=19, LSRW=20. Flag vectors are ordered {H,N,Z,V,C} from bit 4 down to bit 0. ADD returns a[7:0]+b[7:0] and ADC adds `carry_i` as well. Both write all five flags, with C the unsigned carry out and V the signed overflow. For example, $56+$B0 gives $06 with C=1 and V=0, and $56+$60 gives $B6 with C=0 and V=1.
- R2: H is the carry out of bit 3 into bit 4. Only ADD and ADC write H. Every other operation leaves H at its `flags_i` value.
- R3: SUB returns a−b and SBC returns a−b−`carry_i`. Both write N, Z, V and C. C is set when the unsigned minuend is smaller than the subtrahend plus the borrow, and V flags signed overflow.
- R4: CMP (8-bit) and CMPW (16-bit) set N, Z, V and C exactly as a subtract would, and deassert `result_we_o`. For example, CMPW of $504F against $5100 gives N=1, Z=0, V=0, C=1.
- R5: AND, OR and XOR write the bitwise result, set N and Z from it, clear V, and do not write C or H.
- R6: COM returns the one's complement of a, sets N and Z from it, clears V and sets C.
- R7: TST sets N and Z from a and clears both V and C. It does not write the result.
- R8: BIT sets N and Z from a AND b and clears V. It does not write C or the result, and C keeps its `flags_i` value.
- R9: ROL and ROR move the 8 operand bits and the carry one place around a 9-bit ring. C receives the bit that leaves the operand. For example, ROL of $3B with C=1 gives $77 with C=0, and nine successive rotates in one direction restore both the operand and C.
- R10: ASL inserts 0 at bit 0. ASR repeats bit 7. LSR inserts 0 at bit 7. In each case C takes the bit shifted out, and V = N XOR C.
- R11: The 16-bit operations ADDW, SUBW, ASLW and LSRW work on all 16 bits of a and b, ignore `carry_i`, and write N, Z, V and C but not H. N is bit 15 and Z covers all 16 bits.
- R12: Whenever N or Z is written, N equals the MSB of `result_o` (bit 7, or bit 15 for 16-bit operations) and Z is set exactly when the result is zero. For byte operations the upper byte of `result_o` is zero.
- R13: Opcodes 21 to 31 write nothing: all enables are low and `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 16 | First operand (byte operations use bits 7:0) |
| b_i | input | 16 | Second operand (byte operations use bits 7:0) |
| carry_i | input | 1 | Incoming carry for ADC, SBC, ROL and ROR |
| flags_i | input | 5 | Present flags {H,N,Z,V,C} |
| result_o | output | 16 | Operation result |
| result_we_o | output | 1 | Result should be written back |
| flags_o | output | 5 | Next flags {H,N,Z,V,C} |
| flag_we_o | output | 5 | Per-flag write enable, same order |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle as the operand that provokes it. What matters is steering each operation into the corner that exposes it. Carry, borrow and overflow are driven to both polarities. Half-carry is exercised on its own nibble boundary. Inputs are preloaded with flags that an operation must preserve, so a flag write that should have been masked changes `flags_o` visibly. Nine chained rotates catch a carry-ring fault that a single rotate could hide. The write enables are checked alongside the values, because a compare or bit test that leaks a result write would corrupt an accumulator one cycle later in the surrounding datapath.

// File: rtl/alu8_pkg.sv
// Package: shared widths, opcode encoding and flag positions for the ALU.
// Assumes flags are carried as a 5-bit vector {H,N,Z,V,C}, MSB first.
package alu8_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    localparam int FH = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_COM  = 5'd8,
        OP_TST  = 5'd9,
        OP_BIT  = 5'd10,
        OP_ROL  = 5'd11,
        OP_ROR  = 5'd12,
        OP_ASL  = 5'd13,
        OP_ASR  = 5'd14,
        OP_LSR  = 5'd15,
        OP_ADDW = 5'd16,
        OP_SUBW = 5'd17,
        OP_CMPW = 5'd18,
        OP_ASLW = 5'd19,
        OP_LSRW = 5'd20
    } alu_op_e;

    // Shifter modes
    typedef enum logic [2:0] {
        SH_ROL = 3'd0,
        SH_ROR = 3'd1,
        SH_ASL = 3'd2,
        SH_ASR = 3'd3,
        SH_LSR = 3'd4
    } shift_mode_e;

    // Bitwise unit selects
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_COM = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
// Module: parameterized adder/subtractor.
// Computes a+b+cin, or a-b-cin when sub is high, and reports the unsigned
// carry (borrow for subtract), the signed overflow and the carry out of
// bit 3. Assumes W > 4.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf,
    output logic         half
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;

    // Subtract is done as a plus inverted b plus inverted borrow
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    end

    // Derive status bits from the raw sum
    always_comb begin
        sum   = full[W-1:0];
        carry = sub ? ~full[W] : full[W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        half  = sum[4] ^ a[4] ^ b_eff[4];
    end
endmodule

// File: rtl/alu8_shift.sv
// Module: one-place shifter/rotator of parameter width.
// Rotates pass through the carry (a ring of W+1 bits); shifts insert 0
// or repeat the sign. cout is the bit that leaves the operand.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  shift_mode_e  mode,
    output logic [W-1:0] r,
    output logic         cout
);
    localparam int MSB = W - 1;

    // Select the fill bit and direction per mode
    always_comb begin
        unique case (mode)
            SH_ROL: begin r = {a[MSB-1:0], cin};      cout = a[MSB]; end
            SH_ROR: begin r = {cin, a[MSB:1]};        cout = a[0];   end
            SH_ASL: begin r = {a[MSB-1:0], 1'b0};     cout = a[MSB]; end
            SH_ASR: begin r = {a[MSB], a[MSB:1]};     cout = a[0];   end
            SH_LSR: begin r = {1'b0, a[MSB:1]};       cout = a[0];   end
            default: begin r = a;                     cout = cin;    end
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise unit for AND, OR, XOR and one's complement.
// Purely combinational; the width is a parameter.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] r
);
    // Pick the bitwise function
    always_comb begin
        unique case (sel)
            LG_AND:  r = a & b;
            LG_OR:   r = a | b;
            LG_XOR:  r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu8.sv
// Module: top of the 8-bit ALU with condition codes.
// Combinational: decodes op_i, routes operands to the adder, shifter and
// bitwise units, and builds the result, next flags and write enables.
// Assumes the caller registers the outputs; no state is held here.
module alu8
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              carry_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WORD_W-1:0] result_o,
    output logic              result_we_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] flag_we_o
);
    localparam int HI_W = WORD_W - BYTE_W;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // Byte and word datapaths
    logic [BYTE_W-1:0] as8_sum, sh8_r, lg8_r;
    logic              as8_c, as8_v, as8_h, sh8_c, as8_sub, as8_cin;
    logic [WORD_W-1:0] as16_sum, sh16_r;
    logic              as16_c, as16_v, as16_h_unused, sh16_c, as16_sub;
    shift_mode_e       sh8_mode, sh16_mode;
    logic_sel_e        lg_sel;

    // Decode unit controls from the opcode
    always_comb begin
        as8_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        as8_cin   = ((op == OP_ADC) || (op == OP_SBC)) ? carry_i : 1'b0;
        as16_sub  = (op != OP_ADDW);
        sh16_mode = (op == OP_ASLW) ? SH_ASL : SH_LSR;
        unique case (op)
            OP_ROL:  sh8_mode = SH_ROL;
            OP_ROR:  sh8_mode = SH_ROR;
            OP_ASL:  sh8_mode = SH_ASL;
            OP_ASR:  sh8_mode = SH_ASR;
            default: sh8_mode = SH_LSR;
        endcase
        unique case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            OP_COM:  lg_sel = LG_COM;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_addsub #(.W(BYTE_W)) u_as8 (
        .a(a_i[BYTE_W-1:0]), .b(b_i[BYTE_W-1:0]), .cin(as8_cin), .sub(as8_sub),
        .sum(as8_sum), .carry(as8_c), .ovf(as8_v), .half(as8_h)
    );

    alu8_addsub #(.W(WORD_W)) u_as16 (
        .a(a_i), .b(b_i), .cin(1'b0), .sub(as16_sub),
        .sum(as16_sum), .carry(as16_c), .ovf(as16_v), .half(as16_h_unused)
    );

    alu8_shift #(.W(BYTE_W)) u_sh8 (
        .a(a_i[BYTE_W-1:0]), .cin(carry_i), .mode(sh8_mode),
        .r(sh8_r), .cout(sh8_c)
    );

    alu8_shift #(.W(WORD_W)) u_sh16 (
        .a(a_i), .cin(1'b0), .mode(sh16_mode),
        .r(sh16_r), .cout(sh16_c)
    );

    alu8_logic #(.W(BYTE_W)) u_lg8 (
        .a(a_i[BYTE_W-1:0]), .b(b_i[BYTE_W-1:0]), .sel(lg_sel), .r(lg8_r)
    );

    // Byte-wide value on which N and Z are judged, and its word form
    logic [BYTE_W-1:0] v8;
    logic [WORD_W-1:0] v16;
    logic              wide;

    // Choose the value that reaches result_o
    always_comb begin
        wide = 1'b0;
        v16  = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: v8 = as8_sum;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_BIT:  v8 = lg8_r;
            OP_ROL, OP_ROR, OP_ASL, OP_ASR, OP_LSR: v8 = sh8_r;
            OP_TST:                                 v8 = a_i[BYTE_W-1:0];
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                v8 = '0; v16 = as16_sum; wide = 1'b1;
            end
            OP_ASLW, OP_LSRW: begin
                v8 = '0; v16 = sh16_r; wide = 1'b1;
            end
            default:                                v8 = '0;
        endcase
        result_o = wide ? v16 : {{HI_W{1'b0}}, v8};
    end

    logic n_val, z_val;

    // Sign and zero of whichever width is active
    always_comb begin
        n_val = wide ? v16[WORD_W-1] : v8[BYTE_W-1];
        z_val = wide ? (v16 == '0) : (v8 == '0);
    end

    logic [FLAG_W-1:0] nf, we;

    // Per-operation flag policy
    always_comb begin
        nf          = flags_i;
        we          = '0;
        result_we_o = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                nf          = {as8_h, n_val, z_val, as8_v, as8_c};
                we          = 5'b11111;
                result_we_o = 1'b1;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                nf[FN] = n_val; nf[FZ] = z_val; nf[FV] = as8_v; nf[FC] = as8_c;
                we          = 5'b01111;
                result_we_o = (op != OP_CMP);
            end
            OP_AND, OP_OR, OP_XOR, OP_BIT: begin
                nf[FN] = n_val; nf[FZ] = z_val; nf[FV] = 1'b0;
                we          = 5'b01110;
                result_we_o = (op != OP_BIT);
            end
            OP_COM: begin
                nf[FN] = n_val; nf[FZ] = z_val; nf[FV] = 1'b0; nf[FC] = 1'b1;
                we          = 5'b01111;
                result_we_o = 1'b1;
            end
            OP_TST: begin
                nf[FN] = n_val; nf[FZ] = z_val; nf[FV] = 1'b0; nf[FC] = 1'b0;
                we = 5'b01111;
            end
            OP_ROL, OP_ROR, OP_ASL, OP_ASR, OP_LSR: begin
                nf[FN] = n_val; nf[FZ] = z_val;
                nf[FC] = sh8_c; nf[FV] = n_val ^ sh8_c;
                we          = 5'b01111;
                result_we_o = 1'b1;
            end
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                nf[FN] = n_val; nf[FZ] = z_val; nf[FV] = as16_v; nf[FC] = as16_c;
                we          = 5'b01111;
                result_we_o = (op != OP_CMPW);
            end
            OP_ASLW, OP_LSRW: begin
                nf[FN] = n_val; nf[FZ] = z_val;
                nf[FC] = sh16_c; nf[FV] = n_val ^ sh16_c;
                we          = 5'b01111;
                result_we_o = 1'b1;
            end
            default: ;
        endcase
        flags_o   = nf;
        flag_we_o = we;
    end
endmodule

// File: rtl/alu8_chk.sv
// Module: checker for alu8, bound to every instance of it.
// Holds only immediate assertions, since the unit is combinational and
// has no clock or reset of its own.
module alu8_chk
    import alu8_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [WORD_W-1:0] result_o,
    input logic              result_we_o,
    input logic [FLAG_W-1:0] flags_i,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] flag_we_o
);
    logic is_wide, is_shift;

    // Classify the opcode independently of the design's decode
    always_comb begin
        is_wide  = (op_i >= 5'd16) && (op_i <= 5'd20);
        is_shift = ((op_i >= 5'd11) && (op_i <= 5'd15)) || (op_i == 5'd19) || (op_i == 5'd20);
    end

    // Flag and write-enable relations on the port values
    always_comb begin
        a_r2_h_only_add: assert (!flag_we_o[FH] || op_i == 5'd0 || op_i == 5'd1);
        a_r12_unwritten_kept: assert ((flags_o & ~flag_we_o) == (flags_i & ~flag_we_o));
        a_r12_n_is_msb: assert (!flag_we_o[FN] ||
            flags_o[FN] == (is_wide ? result_o[WORD_W-1] : result_o[BYTE_W-1]));
        a_r12_z_is_zero: assert (!flag_we_o[FZ] ||
            flags_o[FZ] == (is_wide ? (result_o == '0) : (result_o[BYTE_W-1:0] == '0)));
        a_r10_v_is_n_xor_c: assert (!is_shift || flags_o[FV] == (flags_o[FN] ^ flags_o[FC]));
        a_r8_bit_policy: assert (op_i != 5'd10 ||
            (!result_we_o && !flag_we_o[FC] && !flags_o[FV]));
        a_r4_compare_no_result: assert (!(op_i == 5'd4 || op_i == 5'd18) || !result_we_o);
        a_r13_undefined_quiet: assert (op_i <= 5'd20 || (flag_we_o == '0 && !result_we_o));
        a_r6_com_sets_c: assert (op_i != 5'd8 || (flags_o[FC] && !flags_o[FV]));
    end
endmodule

bind alu8 alu8_chk u_chk (
    .op_i(op_i), .result_o(result_o), .result_we_o(result_we_o),
    .flags_i(flags_i), .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/sim_alu8.sv
// Bench: directed scenarios for alu8, one task each, self-checking.
module sim_alu8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [4:0]  op_i;
    logic [15:0] a_i, b_i;
    logic        carry_i;
    logic [4:0]  flags_i;
    logic [15:0] result_o;
    logic        result_we_o;
    logic [4:0]  flags_o, flag_we_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    alu8 u0 (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .flags_i(flags_i),
        .result_o(result_o), .result_we_o(result_we_o),
        .flags_o(flags_o), .flag_we_o(flag_we_o)
    );

    // Drive after a rising edge, settle to the falling edge
    task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic cin, input logic [4:0] fl);
        @(posedge clk);
        #1;
        op_i = op; a_i = a; b_i = b; carry_i = cin; flags_i = fl;
        @(negedge clk);
    endtask

    // Compare one value, log a mismatch
    task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Full-port expectation: result (if checked), flags, enables
    task automatic expect_all(input string tag, input bit chk_res, input logic [15:0] res,
                              input logic [4:0] fl, input logic [4:0] we, input logic rwe);
        if (chk_res) cmp({tag, " result"}, result_o, res);
        cmp({tag, " flags"}, {11'd0, flags_o}, {11'd0, fl});
        cmp({tag, " flag_we"}, {11'd0, flag_we_o}, {11'd0, we});
        cmp({tag, " result_we"}, {15'd0, result_we_o}, {15'd0, rwe});
    endtask

    task automatic t_reset;   // R13 quiet state out of reset
        expect_all("R13 reset", 1'b0, 16'h0, 5'b10101, 5'b00000, 1'b0);
    endtask

    task automatic t_add;     // R1 R2
        apply(5'd0, 16'h56, 16'hB0, 1'b1, 5'b00000);
        expect_all("R1 add 56+B0", 1'b1, 16'h0006, 5'b00001, 5'b11111, 1'b1);
        apply(5'd0, 16'h56, 16'h60, 1'b0, 5'b00000);
        expect_all("R1 add 56+60", 1'b1, 16'h00B6, 5'b01010, 5'b11111, 1'b1);
        apply(5'd1, 16'h0F, 16'h00, 1'b1, 5'b00000);
        expect_all("R2 adc half carry", 1'b1, 16'h0010, 5'b10000, 5'b11111, 1'b1);
        apply(5'd0, 16'hFF, 16'h01, 1'b0, 5'b00000);
        expect_all("R2 add FF+01", 1'b1, 16'h0000, 5'b10101, 5'b11111, 1'b1);
    endtask

    task automatic t_sub;     // R3 R2
        apply(5'd2, 16'h50, 16'h4F, 1'b1, 5'b10000);
        expect_all("R3 sub keeps H", 1'b1, 16'h0001, 5'b10000, 5'b01111, 1'b1);
        apply(5'd2, 16'h00, 16'h01, 1'b0, 5'b00000);
        expect_all("R3 sub borrow", 1'b1, 16'h00FF, 5'b01001, 5'b01111, 1'b1);
        apply(5'd2, 16'h80, 16'h01, 1'b0, 5'b00000);
        expect_all("R3 sub overflow", 1'b1, 16'h007F, 5'b00010, 5'b01111, 1'b1);
        apply(5'd3, 16'h10, 16'h0F, 1'b1, 5'b00000);
        expect_all("R3 sbc to zero", 1'b1, 16'h0000, 5'b00100, 5'b01111, 1'b1);
        apply(5'd3, 16'h00, 16'h00, 1'b1, 5'b00000);
        expect_all("R3 sbc borrow in", 1'b1, 16'h00FF, 5'b01001, 5'b01111, 1'b1);
    endtask

    task automatic t_cmp;     // R4
        apply(5'd4, 16'h50, 16'h4F, 1'b0, 5'b00000);
        expect_all("R4 cmp 50/4F", 1'b0, 16'h0, 5'b00000, 5'b01111, 1'b0);
        apply(5'd18, 16'h504F, 16'h5100, 1'b0, 5'b10000);
        expect_all("R4 cmpw 504F/5100", 1'b0, 16'h0, 5'b11001, 5'b01111, 1'b0);
    endtask

    task automatic t_logic;   // R5
        apply(5'd5, 16'hF0, 16'h0F, 1'b0, 5'b10011);
        expect_all("R5 and zero", 1'b1, 16'h0000, 5'b10101, 5'b01110, 1'b1);
        apply(5'd6, 16'h80, 16'h01, 1'b0, 5'b00000);
        expect_all("R5 or", 1'b1, 16'h0081, 5'b01000, 5'b01110, 1'b1);
        apply(5'd7, 16'hFF, 16'hFF, 1'b0, 5'b00001);
        expect_all("R5 xor", 1'b1, 16'h0000, 5'b00101, 5'b01110, 1'b1);
    endtask

    task automatic t_com;     // R6
        apply(5'd8, 16'h55, 16'h00, 1'b0, 5'b00010);
        expect_all("R6 com", 1'b1, 16'h00AA, 5'b01001, 5'b01111, 1'b1);
    endtask

    task automatic t_tst;     // R7
        apply(5'd9, 16'h00, 16'h00, 1'b1, 5'b10011);
        expect_all("R7 tst zero", 1'b0, 16'h0, 5'b10100, 5'b01111, 1'b0);
        apply(5'd9, 16'h80, 16'h00, 1'b0, 5'b00000);
        expect_all("R7 tst neg", 1'b0, 16'h0, 5'b01000, 5'b01111, 1'b0);
    endtask

    task automatic t_bit;     // R8
        apply(5'd10, 16'h1A, 16'h03, 1'b0, 5'b00011);
        expect_all("R8 bit nonzero", 1'b0, 16'h0, 5'b00001, 5'b01110, 1'b0);
        apply(5'd10, 16'h1A, 16'h05, 1'b0, 5'b00000);
        expect_all("R8 bit zero", 1'b0, 16'h0, 5'b00100, 5'b01110, 1'b0);
    endtask

    task automatic t_rotate;  // R9
        logic [7:0] v;
        logic       c;
        apply(5'd11, 16'h3B, 16'h0, 1'b1, 5'b00000);
        expect_all("R9 rol 3B", 1'b1, 16'h0077, 5'b00000, 5'b01111, 1'b1);
        apply(5'd12, 16'h01, 16'h0, 1'b0, 5'b00000);
        expect_all("R9 ror 01", 1'b1, 16'h0000, 5'b00111, 5'b01111, 1'b1);
        apply(5'd12, 16'h00, 16'h0, 1'b1, 5'b00000);
        expect_all("R9 ror carry in", 1'b1, 16'h0080, 5'b01010, 5'b01111, 1'b1);
        for (int dir = 0; dir < 2; dir++) begin
            v = 8'hA5; c = 1'b1;
            for (int k = 0; k < 9; k++) begin
                apply(dir == 0 ? 5'd11 : 5'd12, {8'h0, v}, 16'h0, c, 5'b00000);
                v = result_o[7:0];
                c = flags_o[0];
            end
            cmp("R9 nine rotates value", {8'h0, v}, 16'h00A5);
            cmp("R9 nine rotates carry", {15'h0, c}, 16'h0001);
        end
    endtask

    task automatic t_shift;   // R10
        apply(5'd13, 16'h81, 16'h0, 1'b0, 5'b00000);
        expect_all("R10 asl", 1'b1, 16'h0002, 5'b00011, 5'b01111, 1'b1);
        apply(5'd14, 16'h81, 16'h0, 1'b0, 5'b00000);
        expect_all("R10 asr", 1'b1, 16'h00C0, 5'b01001, 5'b01111, 1'b1);
        apply(5'd15, 16'h81, 16'h0, 1'b1, 5'b00000);
        expect_all("R10 lsr", 1'b1, 16'h0040, 5'b00011, 5'b01111, 1'b1);
        apply(5'd15, 16'h01, 16'h0, 1'b0, 5'b00000);
        expect_all("R10 lsr to zero", 1'b1, 16'h0000, 5'b00111, 5'b01111, 1'b1);
    endtask

    task automatic t_wide;    // R11 R12
        apply(5'd16, 16'h7FFF, 16'h0001, 1'b1, 5'b10000);
        expect_all("R11 addw overflow", 1'b1, 16'h8000, 5'b11010, 5'b01111, 1'b1);
        apply(5'd16, 16'hFFFF, 16'h0001, 1'b0, 5'b00000);
        expect_all("R11 addw wrap", 1'b1, 16'h0000, 5'b00101, 5'b01111, 1'b1);
        apply(5'd17, 16'h0100, 16'h0001, 1'b1, 5'b00000);
        expect_all("R12 subw N on bit15", 1'b1, 16'h00FF, 5'b00000, 5'b01111, 1'b1);
        apply(5'd19, 16'h8001, 16'h0, 1'b0, 5'b00000);
        expect_all("R11 aslw", 1'b1, 16'h0002, 5'b00011, 5'b01111, 1'b1);
        apply(5'd20, 16'h0001, 16'h0, 1'b0, 5'b00000);
        expect_all("R11 lsrw", 1'b1, 16'h0000, 5'b00111, 5'b01111, 1'b1);
    endtask

    task automatic t_undef;   // R13
        apply(5'd21, 16'h1234, 16'h5678, 1'b1, 5'b01010);
        expect_all("R13 op 21", 1'b0, 16'h0, 5'b01010, 5'b00000, 1'b0);
        apply(5'd31, 16'hFFFF, 16'hFFFF, 1'b1, 5'b10101);
        expect_all("R13 op 31", 1'b0, 16'h0, 5'b10101, 5'b00000, 1'b0);
    endtask

    // Print the one summary line
    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    // Main sequence
    initial begin
        op_i = 5'd31; a_i = '0; b_i = '0; carry_i = 1'b0; flags_i = 5'b10101;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_com();
        t_tst();
        t_bit();
        t_rotate();
        t_shift();
        t_wide();
        t_undef();
        done = 1'b1;
        finish_run();
    end
endmodule